// File: doc/BRIEF.md
# Strobed Multiplexed-Address DRAM Access Controller

This block is a clocked model of the control side of a small dynamic memory. Row and column addresses share one narrow bus and are strobed in one after the other by two active-low strobes. The row strobe opens a row. The column strobe then picks a word in that row and performs the access. Once the column strobe rises, the row is restored. When the row strobe rises, the block precharges before it accepts the next row. Storage is a plain register array made of one single-bit plane per data bit, so bit i of every word lives in plane i.

Both strobes are sampled on the block clock, and every timing minimum is a whole number of clock edges. An "edge where a strobe falls" is the first rising clock edge that samples the strobe low after it was sampled high, and a "rise" is defined the same way. The controller sends a small struct of strobes to the datapath, which holds the address latches, the planes and the read register. Strobe sequences that break the ordering rules set a sticky error flag and abort the access in progress. The default geometry is 32 rows by 16 columns. Setting ROW_BITS=8 and COL_BITS=7 gives the full 256-row by 128-column, 32K-word arrangement with an 8-bit address bus.

Top module: `mux_dram_ctrl`

## Requirements
- R1: The address bus is ROW_BITS wide. The row is the whole bus, sampled at the edge where rasN falls. The column is the low COL_BITS bits of the bus, sampled at the edge where casN falls. Bus bits above COL_BITS are ignored for the column. The word index is row*2^COL_BITS + column.
- R2: wrSel is sampled at the casN-fall edge: 1 selects a write and 0 selects a read. A write stores dataIn, sampled one edge after the casN-fall edge, with bit i going into plane i. A later read of the same row and column returns that word.
- R3: On a read, dataOe is high and dataOut carries the addressed word from one clock after the casN-fall edge.
- R4: dataOe stays high until HOLD_CYC edges after the casN-rise edge and then goes low. dataOut is 0 whenever dataOe is low. dataOe stays low for the whole of a write access.
- R5: Reads are non-destructive. Reading the same word again returns the same value. A cycle with rasN only, and no casN fall, leaves the stored data unchanged.
- R6: rowDecEn is high while a row is open and waiting for casN. colDecEn is high from the casN-fall edge until casN rises. senseEn is high from the casN-rise edge until rasN rises. At most one of the three is high at a time, and all three are low while idle or precharging.
- R7: A casN fall seen while rasN is high sets protocolError at that edge and starts no access. protocolError stays set until reset.
- R8: protocolError is set, the access is aborted and dataOe drops at the same edge in either of two cases. The first is a rasN rise while casN is still low. The second is a rasN rise fewer than POST_CYC edges after the casN-rise edge. An abort before the access edge writes nothing.
- R9: After a rasN rise, a rasN fall is accepted only once rasN has been sampled high on PRE_CYC consecutive edges. With the default of 1, a row strobe that is high for a single sampled edge is accepted.
- R10: After reset, dataOe, dataOut, protocolError, rowDecEn, colDecEn and senseEn are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| wrSel | input | 1 | 1 = write, 0 = read, sampled with the column |
| addrBus | input | ROW_BITS | Shared row/column address bus |
| dataIn | input | DATA_W | Write data |
| dataOut | output | DATA_W | Read data, 0 when not driven |
| dataOe | output | 1 | Read data output enable |
| protocolError | output | 1 | Sticky strobe-ordering fault |
| rowDecEn | output | 1 | Row decoder enable |
| colDecEn | output | 1 | Column decoder enable |
| senseEn | output | 1 | Sense/restore enable |

## Verification
Some properties are checked on every cycle by assertions. These are the exclusivity of the three decoder and sense enables, that dataOe only appears in the column or restore phases, that the column phase only follows an open row, that the error flag is sticky and follows a column strobe taken without a row, and that every abort leaves the access phases idle. Other behaviour can only be shown by the bench scenarios, which drive strobe sequences and compare every output with a behavioural model on every clock. These are the stored word values across distinct addresses and bit patterns, the ignored upper column bits, non-destructive re-reads, an aborted write leaving old data, and the boundary cases of a one-cycle column strobe and a one-cycle precharge.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_RESTORE,
    ST_PRECH
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rowCap;
    logic colCap;
    logic rdStb;
    logic wrStb;
    logic oeEn;
  } dpStrobe_t;

endpackage

// File: rtl/mux_dram_ctl.sv
module mux_dram_ctl
  import mux_dram_pkg::*;
#(
  parameter int POST_CYC = 1,
  parameter int HOLD_CYC = 1,
  parameter int PRE_CYC  = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rasN,
  input  logic      casN,
  input  logic      wrSel,
  output dpStrobe_t stb,
  output logic      rowDecEn,
  output logic      colDecEn,
  output logic      senseEn,
  output logic      protocolError
);

  localparam int LIM_PH  = (POST_CYC > HOLD_CYC) ? POST_CYC : HOLD_CYC;
  localparam int CNT_LIM = (LIM_PH > PRE_CYC) ? LIM_PH : PRE_CYC;
  localparam int CNT_W   = $clog2(CNT_LIM + 1);

  phase_e phase, phaseNxt;
  logic rasQ, casQ;
  logic [CNT_W-1:0] phCnt;
  logic accPend, isWrite, oeQ, errQ;
  logic rasFall, rasRise, casFall, casRise;
  logic preDone, postOk, holdDone, rowTake, colTake, accNow, fault;

  assign rasFall = rasQ & ~rasN;
  assign rasRise = ~rasQ & rasN;
  assign casFall = casQ & ~casN;
  assign casRise = ~casQ & casN;

  assign preDone  = (phase == ST_PRECH) && (int'(phCnt) >= PRE_CYC);
  assign postOk   = int'(phCnt) >= POST_CYC;
  assign holdDone = int'(phCnt) >= HOLD_CYC;
  assign rowTake  = rasFall && ((phase == ST_IDLE) || preDone);
  assign colTake  = (phase == ST_ROW) && !rasRise && casFall;
  assign accNow   = (phase == ST_COL) && !rasRise && accPend;
  assign fault    = (casFall && rasN)
                  || (rasRise && (phase == ST_COL))
                  || (rasRise && (phase == ST_RESTORE) && !postOk);

  always_comb begin
    phaseNxt = phase;
    case (phase)
      ST_IDLE:    if (rowTake) phaseNxt = ST_ROW;
      ST_ROW:     if (rasRise) phaseNxt = ST_PRECH;
                  else if (colTake) phaseNxt = ST_COL;
      ST_COL:     if (rasRise) phaseNxt = ST_PRECH;
                  else if (casRise) phaseNxt = ST_RESTORE;
      ST_RESTORE: if (rasRise) phaseNxt = ST_PRECH;
      ST_PRECH:   if (preDone) phaseNxt = rowTake ? ST_ROW : ST_IDLE;
      default:    phaseNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= ST_IDLE;
      rasQ    <= 1'b1;
      casQ    <= 1'b1;
      phCnt   <= '0;
      accPend <= 1'b0;
      isWrite <= 1'b0;
      oeQ     <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      rasQ  <= rasN;
      casQ  <= casN;
      phase <= phaseNxt;
      if (phaseNxt != phase) phCnt <= CNT_W'(1);
      else if (int'(phCnt) < CNT_LIM) phCnt <= phCnt + 1'b1;
      if (colTake) begin
        accPend <= 1'b1;
        isWrite <= wrSel;
      end else if (phase == ST_COL) begin
        accPend <= 1'b0;
      end
      if (accNow && !isWrite) oeQ <= 1'b1;
      else if ((phaseNxt == ST_PRECH) || ((phase == ST_RESTORE) && holdDone)) oeQ <= 1'b0;
      if (fault) errQ <= 1'b1;
    end
  end

  always_comb begin
    stb.rowCap = rowTake;
    stb.colCap = colTake;
    stb.rdStb  = accNow && !isWrite;
    stb.wrStb  = accNow && isWrite;
    stb.oeEn   = oeQ;
  end

  assign rowDecEn      = (phase == ST_ROW);
  assign colDecEn      = (phase == ST_COL);
  assign senseEn       = (phase == ST_RESTORE);
  assign protocolError = errQ;

endmodule

// File: rtl/mux_dram_dp.sv
module mux_dram_dp
  import mux_dram_pkg::*;
#(
  parameter int ROW_BITS = 5,
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic [ROW_BITS-1:0] addrBus,
  input  logic [DATA_W-1:0]   dataIn,
  input  dpStrobe_t           stb,
  output logic [DATA_W-1:0]   dataOut
);

  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ROW_BITS-1:0] rowAddr;
  logic [COL_BITS-1:0] colAddr;
  logic [ADDR_W-1:0]   wordAddr;
  logic [DATA_W-1:0]   rdWord;

  always_ff @(posedge clk) begin
    if (stb.rowCap) rowAddr <= addrBus;
    if (stb.colCap) colAddr <= addrBus[COL_BITS-1:0];
  end

  assign wordAddr = {rowAddr, colAddr};

  for (genvar g = 0; g < DATA_W; g++) begin : gPlane
    logic plane [DEPTH];
    logic rdBit;
    always_ff @(posedge clk) begin
      if (stb.wrStb) plane[wordAddr] <= dataIn[g];
      if (stb.rdStb) rdBit <= plane[wordAddr];
    end
    assign rdWord[g] = rdBit;
  end

  assign dataOut = stb.oeEn ? rdWord : '0;

endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import mux_dram_pkg::*;
#(
  parameter int ROW_BITS = 5,
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 8,
  parameter int POST_CYC = 1,
  parameter int HOLD_CYC = 1,
  parameter int PRE_CYC  = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rasN,
  input  logic                casN,
  input  logic                wrSel,
  input  logic [ROW_BITS-1:0] addrBus,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe,
  output logic                protocolError,
  output logic                rowDecEn,
  output logic                colDecEn,
  output logic                senseEn
);

  dpStrobe_t stb;

  mux_dram_ctl #(
    .POST_CYC(POST_CYC),
    .HOLD_CYC(HOLD_CYC),
    .PRE_CYC (PRE_CYC)
  ) i_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .rasN         (rasN),
    .casN         (casN),
    .wrSel        (wrSel),
    .stb          (stb),
    .rowDecEn     (rowDecEn),
    .colDecEn     (colDecEn),
    .senseEn      (senseEn),
    .protocolError(protocolError)
  );

  mux_dram_dp #(
    .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS),
    .DATA_W  (DATA_W)
  ) i_dp (
    .clk    (clk),
    .addrBus(addrBus),
    .dataIn (dataIn),
    .stb    (stb),
    .dataOut(dataOut)
  );

  assign dataOe = stb.oeEn;

endmodule

// File: rtl/mux_dram_chk.sv
module mux_dram_chk (
  input logic clk,
  input logic rstN,
  input logic rasN,
  input logic casN,
  input logic dataOe,
  input logic protocolError,
  input logic rowDecEn,
  input logic colDecEn,
  input logic senseEn
);

  logic casPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) casPrev <= 1'b1;
    else       casPrev <= casN;
  end

  assert_enables_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rowDecEn, colDecEn, senseEn}));

  assert_col_after_row_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(colDecEn) |-> $past(rowDecEn));

  assert_row_after_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rowDecEn) |-> !$past(rasN));

  assert_oe_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (colDecEn || senseEn));

  assert_oe_after_col_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $past(colDecEn));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    protocolError |=> protocolError);

  assert_cas_without_ras_R7: assert property (@(posedge clk) disable iff (!rstN)
    (casPrev && !casN && rasN) |=> protocolError);

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protocolError) |-> (!colDecEn && !senseEn && !dataOe));

endmodule

bind mux_dram_ctrl mux_dram_chk i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rasN         (rasN),
  .casN         (casN),
  .dataOe       (dataOe),
  .protocolError(protocolError),
  .rowDecEn     (rowDecEn),
  .colDecEn     (colDecEn),
  .senseEn      (senseEn)
);

// File: tb/test_mux_dram_ctrl.sv
module test_mux_dram_ctrl;

  localparam int RB = 5;
  localparam int CB = 4;
  localparam int ROWS = 1 << RB;
  localparam int COLS = 1 << CB;
  localparam int POSTM = 1;
  localparam int HOLDM = 1;
  localparam int PREM  = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, wrSel = 1'b0;
  logic [RB-1:0] addrBus = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe, protocolError, rowDecEn, colDecEn, senseEn;

  int checks = 0;
  int errors = 0;
  logic [7:0] sb [int];

  mux_dram_ctrl i_mux_dram_ctrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .wrSel(wrSel),
    .addrBus(addrBus), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .protocolError(protocolError), .rowDecEn(rowDecEn), .colDecEn(colDecEn),
    .senseEn(senseEn)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference, advanced on every rising edge
  int mPhase = 0;   // 0 idle, 1 row open, 2 column, 3 restore, 4 precharge
  int mCnt = 0;
  int mKey = 0;
  bit mPrevRas = 1, mPrevCas = 1, mFirst = 0, mWr = 0;
  bit eOe = 0, eErr = 0;
  logic [7:0] eWord = '0;
  logic [7:0] mMem [int];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mPrevRas = 1; mPrevCas = 1; mFirst = 0;
      eOe = 0; eErr = 0; eWord = '0;
    end else begin
      bit rf, rr, cf, cr;
      rf = mPrevRas && !rasN;
      rr = !mPrevRas && rasN;
      cf = mPrevCas && !casN;
      cr = !mPrevCas && casN;
      if (cf && rasN) eErr = 1;
      case (mPhase)
        0: if (rf) begin mKey = int'(addrBus) * COLS; mPhase = 1; end
        1: begin
          if (rr) begin mPhase = 4; mCnt = 1; end
          else if (cf) begin
            mKey = mKey + (int'(addrBus) % COLS);
            mWr = wrSel; mFirst = 1; mPhase = 2;
          end
        end
        2: begin
          if (rr) begin eErr = 1; eOe = 0; mPhase = 4; mCnt = 1; end
          else begin
            if (mFirst) begin
              mFirst = 0;
              if (mWr) mMem[mKey] = dataIn;
              else begin eOe = 1; eWord = mMem[mKey]; end
            end
            if (cr) begin mPhase = 3; mCnt = 1; end
          end
        end
        3: begin
          if (rr) begin
            if (mCnt < POSTM) eErr = 1;
            eOe = 0; mPhase = 4; mCnt = 1;
          end else begin
            if (mCnt >= HOLDM) eOe = 0;
            mCnt++;
          end
        end
        default: begin
          if (mCnt >= PREM) begin
            if (rf) begin mKey = int'(addrBus) * COLS; mPhase = 1; end
            else mPhase = 0;
          end else mCnt++;
        end
      endcase
      mPrevRas = rasN;
      mPrevCas = casN;
    end
  end

  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      chk("R4 model dataOe", dataOe, eOe);
      chk("R3 model dataOut", dataOut, eOe ? eWord : 8'h00);
      chk("R7 model protocolError", protocolError, eErr);
      chk("R6 model enables", {rowDecEn, colDecEn, senseEn},
          {mPhase == 1, mPhase == 2, mPhase == 3});
    end
  end

  task automatic access(input int row, input int col, input bit wr, input logic [7:0] d,
                        input int casLow, input int postLow, input int pre);
    int key;
    key = (row % ROWS) * COLS + (col % COLS);
    addrBus = RB'(row); rasN = 1'b0;
    cyc(1);
    chk("R6 row open enable", {rowDecEn, colDecEn, senseEn}, 3'b100);
    addrBus = RB'(col); wrSel = wr; dataIn = d; casN = 1'b0;
    cyc(1);
    chk("R6 column enable", {rowDecEn, colDecEn, senseEn}, 3'b010);
    if (casLow == 1) casN = 1'b1;
    cyc(1);
    if (wr) begin
      chk("R4 dataOe low on write", dataOe, 1'b0);
      sb[key] = d;
    end else begin
      chk("R3 dataOe one cycle after column", dataOe, 1'b1);
      chk("R2 read word", dataOut, sb[key]);
    end
    if (casLow > 1) begin
      cyc(casLow - 2);
      casN = 1'b1;
      cyc(1);
    end
    cyc(postLow - 1);
    rasN = 1'b1;
    cyc(pre);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R10 reset state
    chk("R10 reset outputs", {dataOe, protocolError, rowDecEn, colDecEn, senseEn}, 5'b0);
    chk("R10 reset dataOut", dataOut, 8'h00);

    // R2 basic write and read
    access(3, 5, 1, 8'hA5, 2, 1, 2);
    access(3, 5, 0, 8'h00, 2, 1, 2);

    // R1 swapped row/column distinguish words
    access(7, 2, 1, 8'h3C, 2, 1, 2);
    access(2, 7, 1, 8'hC3, 2, 1, 2);
    access(7, 2, 0, 8'h00, 2, 1, 2);
    access(2, 7, 0, 8'h00, 2, 1, 2);

    // R2 several bit patterns across planes
    for (int i = 0; i < 6; i++)
      access((i * 5 + 1) % ROWS, (i * 3) % COLS, 1, 8'(i * 37 + 11), 3, 1, 1);
    for (int i = 0; i < 6; i++)
      access((i * 5 + 1) % ROWS, (i * 3) % COLS, 0, 8'h00, 3, 1, 1);
    access(31, 15, 1, 8'hFF, 2, 1, 1);
    access(0, 0, 1, 8'h00, 2, 1, 1);
    access(31, 15, 0, 8'h00, 2, 1, 1);
    access(0, 0, 0, 8'h00, 2, 1, 1);

    // R1 upper bus bit ignored for the column: 0x13 selects column 3
    access(9, 8'h13, 1, 8'h5A, 2, 1, 2);
    access(9, 3, 0, 8'h00, 2, 1, 2);
    chk("R1 upper column bit ignored", dataOut, 8'h00); // oe dropped by now
    access(9, 3, 0, 8'h00, 2, 1, 2);

    // R5 repeated reads and a RAS-only cycle
    access(7, 2, 0, 8'h00, 2, 1, 2);
    access(7, 2, 0, 8'h00, 2, 1, 2);
    addrBus = RB'(7); rasN = 1'b0;
    cyc(3);
    rasN = 1'b1;
    cyc(2);
    access(7, 2, 0, 8'h00, 2, 1, 2);
    chk("R5 word kept after refresh", sb[7 * COLS + 2], 8'h3C);

    // R3/R4 single-cycle column strobe, long column strobe, long post window
    access(3, 5, 0, 8'h00, 1, 1, 2);
    access(3, 5, 0, 8'h00, 5, 3, 2);

    // R9 back-to-back with one precharge edge
    access(2, 7, 0, 8'h00, 2, 1, 1);
    chk("R9 next row accepted after one high edge", protocolError, 1'b0);
    access(7, 2, 0, 8'h00, 2, 1, 1);

    // R7 column strobe without row strobe
    casN = 1'b0;
    cyc(1);
    chk("R7 cas without ras sets error", protocolError, 1'b1);
    chk("R7 no access started", {rowDecEn, colDecEn, senseEn, dataOe}, 4'b0);
    casN = 1'b1;
    cyc(3);
    chk("R7 error sticky", protocolError, 1'b1);
    doReset();
    chk("R10 reset clears error", protocolError, 1'b0);

    // R8 row strobe rising while column strobe low aborts a write
    addrBus = RB'(3); rasN = 1'b0;
    cyc(1);
    addrBus = RB'(5); wrSel = 1'b1; dataIn = 8'hEE; casN = 1'b0;
    cyc(1);
    rasN = 1'b1;
    cyc(1);
    chk("R8 early ras rise sets error", protocolError, 1'b1);
    chk("R8 abort leaves phases idle", {colDecEn, senseEn, dataOe}, 3'b0);
    casN = 1'b1;
    cyc(2);
    doReset();

    // R8 row strobe rising at the column-rise edge; also proves no write happened
    addrBus = RB'(3); rasN = 1'b0;
    cyc(1);
    addrBus = RB'(5); wrSel = 1'b0; casN = 1'b0;
    cyc(2);
    chk("R8 aborted write left old data", dataOut, 8'hA5);
    casN = 1'b1; rasN = 1'b1;
    cyc(1);
    chk("R8 ras rise inside post window sets error", protocolError, 1'b1);
    chk("R8 output dropped on abort", dataOe, 1'b0);
    cyc(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule